// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in either direction. Each direction has its own storage path. The path can pass data straight through as a transparent latch, hold a captured word, or capture a new word on the rising edge of a per-direction strobe when the active-low enable for that strobe is asserted. Each direction also has its own active-low drive enable, which decides whether the destination port is driven.

The block sits in a system-clock domain. The per-direction strobes are treated as data and sampled on `clk`. A rising strobe is a sample of 1 that follows a sample of 0, and the capture takes effect after the system edge that first sees the strobe high. Transparent data flows through combinationally.

Each port is modelled as a pad. Each pad has an input value, a per-bit "floating" indication, an output value and an output drive flag. A floating bit keeps the last value it resolved to. A synchronous active-high reset holds both drive flags low.

Top module: `latch_reg_xcvr`

## Requirements
- R1: The two directions are independent. The B-to-A path uses only the `ba_*` controls and `b_in`/`b_z`. Toggling the A-to-B controls never changes `a_out`.
- R2: While a direction's latch enable is 1, its destination output equals the resolved source value in the same cycle, with no strobe needed.
- R3: While the latch enable is 0 and the strobe stays at a steady level, the destination output does not change.
- R4: While the latch enable is 0 and the strobe enable is 0, a strobe rise captures the source. The new value appears on the destination output after the system clock edge that first samples the strobe at 1 after a 0.
- R5: While the strobe enable is 1, strobe rises are ignored and the stored word is kept.
- R6: A destination drive flag is 1 exactly when that direction's drive enable is 0 and reset is not in effect.
- R7: When the latch enable falls, the stored word is the source value present at the last system edge while the latch was open. That word is kept until a qualified strobe rise.
- R8: A source bit whose floating flag is 1 resolves to that bit's last resolved value. Non-floating bits resolve to the pad input.
- R9: While reset is 1, both drive flags are 0 one system edge later. Reset also clears both stored words and the bus keepers to 0.
- R10: `contention` is 1 exactly when both drive flags are 1 at the same time.
- R11: A strobe rise that arrives while the latch enable is 1 has no effect beyond transparency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Value read at pad A |
| a_z | input | 18 | Per-bit floating flag for pad A |
| a_out | output | 18 | Value to drive onto pad A (B-to-A path) |
| a_oe | output | 1 | Drive flag for pad A |
| b_in | input | 18 | Value read at pad B |
| b_z | input | 18 | Per-bit floating flag for pad B |
| b_out | output | 18 | Value to drive onto pad B (A-to-B path) |
| b_oe | output | 1 | Drive flag for pad B |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_ck | input | 1 | A-to-B capture strobe |
| ab_cke_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_ck | input | 1 | B-to-A capture strobe |
| ba_cke_n | input | 1 | B-to-A strobe enable, active low |
| contention | output | 1 | Both pads driven at once |

## Verification
Two functions can meet in one system cycle.

The first pair is a strobe rise and an open latch. The bench raises `ab_ck` with `ab_cke_n` low while `ab_le` is 1. It then closes the latch on the next cycle and changes the source at the same moment. The output must still show the word that was flowing through at the last open edge (R7, R11).

The second pair is a disabled strobe rise and the hold state. The bench judges this by checking that the output is unchanged.

Contention is provoked by enabling both directions' drives together while the B-to-A path is transparent. The bench checks that the flag rises and that the A-side data is untouched by A-to-B strobing.

// File: rtl/latch_reg_xcvr_pkg.sv
package latch_reg_xcvr_pkg;

    localparam int unsigned XCV_WIDTH = 18;

    // control bundle for one transfer direction
    typedef struct packed {
        logic oe_n;
        logic le;
        logic ck;
        logic cke_n;
    } dir_ctl_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_FOLLOW = 2'd1,
        ACT_LOAD   = 2'd2
    } store_act_e;

    // transparency wins over a strobe rise; a disabled strobe holds
    function automatic store_act_e pick_act(input logic le,
                                            input logic rise,
                                            input logic cke_n);
        if (le)
            return ACT_FOLLOW;
        else if (rise && !cke_n)
            return ACT_LOAD;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/xcv_keeper.sv
module xcv_keeper
    #(parameter int unsigned W = 18)
(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] flt,
    output logic [W-1:0] res
);

    logic [W-1:0] kept_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i] = flt[i] ? kept_q[i] : pin[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            kept_q <= '0;
        else
            kept_q <= res;
    end

endmodule

// File: rtl/xcv_store.sv
module xcv_store
    import latch_reg_xcvr_pkg::*;
    #(parameter int unsigned W = 18)
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ready,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic         dst_oe
);

    logic         ck_q;
    logic         rise;
    store_act_e   act;
    logic [W-1:0] word_q;

    // strobe history follows the pin even in reset so no false rise appears
    always_ff @(posedge clk) begin
        ck_q <= ctl.ck;
    end

    assign rise = ctl.ck & ~ck_q;
    assign act  = pick_act(ctl.le, rise, ctl.cke_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            unique case (act)
                ACT_FOLLOW, ACT_LOAD: word_q <= src;
                default:              word_q <= word_q;
            endcase
        end
    end

    assign dst    = ctl.le ? src : word_q;
    assign dst_oe = ready & ~ctl.oe_n;

endmodule

// File: rtl/latch_reg_xcvr.sv
module latch_reg_xcvr
    import latch_reg_xcvr_pkg::*;
    #(parameter int unsigned W = XCV_WIDTH)
(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_z,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_z,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_ck,
    input  logic         ab_cke_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_ck,
    input  logic         ba_cke_n,
    output logic         contention
);

    dir_ctl_t     ctl_ab;
    dir_ctl_t     ctl_ba;
    logic [W-1:0] a_res;
    logic [W-1:0] b_res;
    logic         ready_q;

    assign ctl_ab = '{oe_n: ab_oe_n, le: ab_le, ck: ab_ck, cke_n: ab_cke_n};
    assign ctl_ba = '{oe_n: ba_oe_n, le: ba_le, ck: ba_ck, cke_n: ba_cke_n};

    // drives stay off until the first edge after reset is released
    always_ff @(posedge clk) begin
        if (rst)
            ready_q <= 1'b0;
        else
            ready_q <= 1'b1;
    end

    xcv_keeper #(.W(W)) u_keep_a (
        .clk (clk),
        .rst (rst),
        .pin (a_in),
        .flt (a_z),
        .res (a_res)
    );

    xcv_keeper #(.W(W)) u_keep_b (
        .clk (clk),
        .rst (rst),
        .pin (b_in),
        .flt (b_z),
        .res (b_res)
    );

    xcv_store #(.W(W)) u_path_ab (
        .clk    (clk),
        .rst    (rst),
        .ready  (ready_q),
        .ctl    (ctl_ab),
        .src    (a_res),
        .dst    (b_out),
        .dst_oe (b_oe)
    );

    xcv_store #(.W(W)) u_path_ba (
        .clk    (clk),
        .rst    (rst),
        .ready  (ready_q),
        .ctl    (ctl_ba),
        .src    (b_res),
        .dst    (a_out),
        .dst_oe (a_oe)
    );

    assign contention = a_oe & b_oe;

endmodule

// File: rtl/latch_reg_xcvr_chk.sv
module latch_reg_xcvr_chk
    #(parameter int unsigned W = 18)
(
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_z,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_z,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_ck,
    input logic         ab_cke_n,
    input logic         ba_le,
    input logic         ba_oe_n,
    input logic         contention
);

    p_transp_r2: assert property (@(posedge clk) disable iff (rst)
        (ab_le && a_z == '0) |-> b_out == a_in);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && $past(!rst) && $past(!ab_le) && $past(ab_ck) == $past(ab_ck, 2))
        |-> b_out == $past(b_out));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && $past(!rst) && $past(!ab_le) && $past(ab_ck) && !$past(ab_ck, 2)
         && $past(!ab_cke_n) && $past(a_z) == '0)
        |-> b_out == $past(a_in));

    p_cke_r5: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && $past(!rst) && $past(!ab_le) && $past(ab_cke_n))
        |-> b_out == $past(b_out));

    p_oe_on_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> b_oe == !ab_oe_n);

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> !b_oe);

    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (ba_le && &b_z && $past(!rst) && $past(ba_le) && $past(&b_z))
        |-> a_out == $past(a_out));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!a_oe && !b_oe && !contention));

    p_contention_r10: assert property (@(posedge clk) disable iff (rst)
        contention |-> (!ab_oe_n && !ba_oe_n));

endmodule

bind latch_reg_xcvr latch_reg_xcvr_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_z        (a_z),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_z        (b_z),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .ab_oe_n    (ab_oe_n),
    .ab_le      (ab_le),
    .ab_ck      (ab_ck),
    .ab_cke_n   (ab_cke_n),
    .ba_le      (ba_le),
    .ba_oe_n    (ba_oe_n),
    .contention (contention)
);

// File: tb/test_latch_reg_xcvr.sv
`timescale 1ns/1ps
module test_latch_reg_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, a_z, b_in, b_z;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;
    logic         ab_oe_n, ab_le, ab_ck, ab_cke_n;
    logic         ba_oe_n, ba_le, ba_ck, ba_cke_n;
    logic [W-1:0] exp_v;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    latch_reg_xcvr #(.W(W)) i_latch_reg_xcvr (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_z(a_z), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_z(b_z), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck), .ab_cke_n(ab_cke_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck), .ba_cke_n(ba_cke_n),
        .contention(contention)
    );

    // {le, ck, cke_n, a_in, expected b_out after the edge}
    localparam logic [38:0] VEC [0:9] = '{
        {1'b1, 1'b0, 1'b1, 18'h01234, 18'h01234},  // R2 open
        {1'b0, 1'b0, 1'b0, 18'h2AAAA, 18'h01234},  // R3 steady low
        {1'b0, 1'b1, 1'b1, 18'h2AAAA, 18'h01234},  // R5 rise, strobe disabled
        {1'b0, 1'b0, 1'b0, 18'h15555, 18'h01234},  // R3
        {1'b0, 1'b1, 1'b0, 18'h15555, 18'h15555},  // R4 qualified rise
        {1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h15555},  // R3 steady high
        {1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h15555},  // R3
        {1'b1, 1'b1, 1'b0, 18'h00F0F, 18'h00F0F},  // R11 rise while open
        {1'b0, 1'b0, 1'b0, 18'h3C3C3, 18'h00F0F},  // R7 closed keeps word
        {1'b0, 1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3}   // R4
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_in = '0; a_z = '0; b_in = '0; b_z = '0;
        ab_oe_n = 1'b0; ab_le = 1'b0; ab_ck = 1'b0; ab_cke_n = 1'b1;
        ba_oe_n = 1'b0; ba_le = 1'b0; ba_ck = 1'b0; ba_cke_n = 1'b1;
        repeat (3) tick();
        chk("R9 b_oe in reset", W'(b_oe), '0);
        chk("R9 a_oe in reset", W'(a_oe), '0);
        chk("R9 contention in reset", W'(contention), '0);
        ba_oe_n = 1'b1;
        rst = 1'b0;
        tick();
        chk("R6 b_oe after release", W'(b_oe), W'(1));
        chk("R9 stored word cleared", b_out, '0);

        for (int i = 0; i < 10; i++) begin
            {ab_le, ab_ck, ab_cke_n, a_in, exp_v} = VEC[i];
            tick();
            chk($sformatf("R2/R3/R4/R5/R7/R11 vector %0d", i), b_out, exp_v);
        end

        ab_oe_n = 1'b1;
        #1;
        chk("R6 drive off", W'(b_oe), '0);
        ab_oe_n = 1'b0;

        // R1 and R10: B-to-A open while A-to-B strobes with its enable off
        ab_cke_n = 1'b1;
        ba_le = 1'b1;
        ba_oe_n = 1'b0;
        b_in = 18'h2468A;
        a_in = 18'h11111;
        #1;
        chk("R1 a_out follows b_in", a_out, 18'h2468A);
        chk("R10 contention both on", W'(contention), W'(1));
        ab_ck = 1'b0;
        tick();
        ab_ck = 1'b1;
        tick();
        chk("R1 a_out unaffected by A-to-B", a_out, 18'h2468A);
        chk("R5 b_out kept, enable off", b_out, 18'h3C3C3);
        ab_oe_n = 1'b1;
        #1;
        chk("R10 contention cleared", W'(contention), '0);

        // R8 bus keeper on pad B
        b_z = '1;
        b_in = 18'h15555;
        #1;
        chk("R8 all floating keeps", a_out, 18'h2468A);
        b_z = 18'h000FF;
        b_in = 18'h3FF00;
        #1;
        chk("R8 partial float", a_out, 18'h3FF8A);
        tick();
        b_z = '1;
        b_in = 18'h00000;
        #1;
        chk("R8 keeper updated", a_out, 18'h3FF8A);
        b_z = '0;

        // R9 reset mid-run with drive requested
        ab_oe_n = 1'b0;
        ab_le = 1'b0;
        rst = 1'b1;
        tick();
        chk("R9 b_oe forced off", W'(b_oe), '0);
        chk("R9 word cleared mid-run", b_out, '0);
        rst = 1'b0;
        tick();
        chk("R6 b_oe restored", W'(b_oe), W'(1));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule